// File: doc/BRIEF.md
# Winding Current Chopper with Decay Policy

This block holds the current in one stepper-motor winding near a commanded level. It does this by chopping at a fixed frequency. At the start of every PWM period it turns on the diagonal switch pair of a single H-bridge that pushes current in the commanded direction. It keeps that pair on until a digital sense-comparator bit reports that the current has reached its threshold. For the rest of the period it lets the current decay. The block drives four gate-enable outputs, one each for the high and low switches on both legs of the bridge.

The decay behaviour follows a two-bit selector. Slow decay recirculates the current through both low switches. Fast decay reverses the bridge and releases every switch once a zero-current detect bit fires. The mixed setting depends on a "current falling" flag from the indexer. When the flag is set, the period decays fast up to a fixed point at 75% of the period and slow after that. When the flag is clear, the period decays slow. A blanking window measured in clock cycles masks the comparator after drive starts, and this window also sets the shortest possible on-time. A dead-time stage sits between the phase logic and the outputs, so that no switch turns on during the clock in which another switch turns off.

Top module: `winding_chopper`

## Requirements
- R1: While `drv_enable` is low, all four gate outputs are low, and they go low in the same clock in which `drv_enable` falls.
- R2: Position 0 of a period is the clock after the first rising edge with `drv_enable` high, and a new period starts every `PERIOD_CYC` clocks after that. The outputs show the pattern of position p in the clock after position p. Output bits are ordered {hi1, lo1, hi2, lo2}. The drive pattern for `cur_sign`=1 is 4'b1001 (current flows out of terminal 1). The drive pattern for `cur_sign`=0 is 4'b0110.
- R3: `sense_trip` is ignored at positions below `BLANK_CYC`. A trip seen at position p ≥ `BLANK_CYC` ends drive from position p+1. With no trip, drive lasts for the whole period.
- R4: Once drive has ended in a period, it does not resume before the next period, even when `sense_trip` falls.
- R5: With `decay_sel`=2'b00, the decay pattern is 4'b0101 (both low switches on), and `zero_cross` has no effect.
- R6: With `decay_sel`=2'b01, the decay pattern is the reverse of the drive pattern. A `zero_cross` seen in that state switches off all four outputs for the rest of the period.
- R7: With `decay_sel` set to 2'b10 or 2'b11 and `cur_falling`=1, decay runs as fast decay (including the zero stop) up to position `MIX_POS` = 75% of the period. From `MIX_POS` onward it is slow decay.
- R8: With a mixed setting and `cur_falling`=0, decay is slow for the whole period.
- R9: `cur_sign`, `decay_sel` and `cur_falling` are captured at each period start. Changes later in the period act only from the next period.
- R10: The high and low switch of the same leg are never on together. When the pattern changes, switches that leave turn off first. Switches that join wait `DEAD_CYC` clocks with no switch on that has to go. Switches common to both patterns stay on.
- R11: When `drv_enable` returns high, the period restarts at position 0 with a full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_enable | input | 1 | Global enable; low forces every switch off |
| sense_trip | input | 1 | Current reached threshold (synchronous) |
| zero_cross | input | 1 | Winding current near zero (synchronous) |
| cur_sign | input | 1 | Commanded current sign, 1 = positive |
| cur_falling | input | 1 | Indexer reports the commanded magnitude is falling |
| decay_sel | input | 2 | 00 slow, 01 fast, 10/11 mixed |
| hi1_on | output | 1 | High switch, leg 1 |
| lo1_on | output | 1 | Low switch, leg 1 |
| hi2_on | output | 1 | High switch, leg 2 |
| lo2_on | output | 1 | Low switch, leg 2 |

## Verification
A period counter that is off by one shows at the ports as early or late drive restarts. It also moves the point where the blanking window ends and the point where mixed decay changes over, so the bench checks the edges next to each of these positions to the exact clock. A trip or zero-stop flag latched in the wrong state shows within one clock as the wrong pattern, or as drive coming back in the middle of a period. Configuration captured at the wrong time shows as a pattern with the wrong sign or the wrong decay in the period after a mid-period change. Errors in the dead-time stage show as a missing or extra all-off or partial pattern in the single clock after each pattern change.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    DK_SLOW   = 2'b00,
    DK_FAST   = 2'b01,
    DK_MIXED  = 2'b10,
    DK_MIXED2 = 2'b11
  } decay_e;

  // Clock cycles covering a time span, rounded up.
  function automatic int span_cycles(input longint clk_hz, input longint span_ns);
    longint prod;
    prod = clk_hz * span_ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Position inside the period at which mixed decay turns slow.
  function automatic int split_point(input int period, input int pct);
    return (period * pct) / 100;
  endfunction

  // Gate word {hi1, lo1, hi2, lo2} for a phase and a current sign.
  function automatic logic [3:0] gate_word(input phase_e ph, input logic pos);
    case (ph)
      PH_DRIVE: return pos ? 4'b1001 : 4'b0110;
      PH_FAST:  return pos ? 4'b0110 : 4'b1001;
      PH_SLOW:  return 4'b0101;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic is_mixed(input decay_e m);
    return (m == DK_MIXED) || (m == DK_MIXED2);
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD_CYC = 1333,
  parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             run,
  output logic [CNT_W-1:0] pos,
  output logic             load
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic at_last;
  assign at_last = (pos == LAST);
  // Next clock is position 0 of a fresh period.
  assign load = en && (!run || at_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      pos <= '0;
    end else if (!en) begin
      run <= 1'b0;
      pos <= '0;
    end else if (load) begin
      run <= 1'b1;
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < PERIOD_CYC);

  // R2
  wrap_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && pos == '0) |-> ($past(pos) == LAST));

endmodule

// File: rtl/chop_phase_seq.sv
module chop_phase_seq
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 1333,
  parameter int BLANK_CYC  = 150,
  parameter int MIX_POS    = 999,
  parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] pos,
  input  logic             trip,
  input  logic             zero,
  input  logic             sign_in,
  input  logic             fall_in,
  input  logic [1:0]       mode_in,
  output phase_e           phase,
  output logic             sign_q
);
  decay_e mode_q;
  logic   fall_q;
  logic   tripped_q;
  logic   zeroed_q;

  logic blank_over;
  logic past_split;
  logic trip_seen;
  logic zero_seen;

  assign blank_over = int'(pos) >= BLANK_CYC;
  assign past_split = int'(pos) >= MIX_POS;

  // Decay phase when fast decay is the active choice.
  phase_e fast_leg;
  assign fast_leg = zeroed_q ? PH_OFF : PH_FAST;

  always_comb begin
    if (!run)               phase = PH_OFF;
    else if (!tripped_q)    phase = PH_DRIVE;
    else begin
      case (mode_q)
        DK_SLOW: phase = PH_SLOW;
        DK_FAST: phase = fast_leg;
        default: phase = (!fall_q || past_split) ? PH_SLOW : fast_leg;
      endcase
    end
  end

  assign trip_seen = run && (phase == PH_DRIVE) && blank_over && trip;
  assign zero_seen = run && (phase == PH_FAST) && zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_q    <= 1'b0;
      mode_q    <= DK_SLOW;
      fall_q    <= 1'b0;
      tripped_q <= 1'b0;
      zeroed_q  <= 1'b0;
    end else if (!en) begin
      tripped_q <= 1'b0;
      zeroed_q  <= 1'b0;
    end else if (load) begin
      sign_q    <= sign_in;
      mode_q    <= decay_e'(mode_in);
      fall_q    <= fall_in;
      tripped_q <= 1'b0;
      zeroed_q  <= 1'b0;
    end else begin
      if (trip_seen) tripped_q <= 1'b1;
      if (zero_seen) zeroed_q  <= 1'b1;
    end
  end

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && int'(pos) < BLANK_CYC) |-> (phase == PH_DRIVE));

  // R4
  no_redrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase != PH_DRIVE && !load) |=> (phase != PH_DRIVE));

  // R6
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_OFF && mode_q == DK_FAST && !load) |=> (phase == PH_OFF));

  // R7
  mixed_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_mixed(mode_q) && past_split && phase != PH_DRIVE) |-> (phase == PH_SLOW));

  // R8
  fast_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FAST) |-> (fall_q || mode_q == DK_FAST));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable({sign_q, mode_q, fall_q}));

endmodule

// File: rtl/chop_gate_deadtime.sv
module chop_gate_deadtime #(
  parameter int DEAD_CYC = 1,
  parameter int DW       = $clog2(DEAD_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] want,
  output logic [3:0] gate_q
);
  logic [3:0]    want_eff;
  logic [3:0]    leaving;
  logic [3:0]    joining;
  logic [3:0]    gate_d;
  logic          settled;
  logic [DW-1:0] gap_q;

  assign want_eff = en ? want : 4'b0000;
  assign leaving  = gate_q & ~want_eff;
  assign joining  = want_eff & ~gate_q;
  assign settled  = (leaving == 4'b0000) && (int'(gap_q) >= DEAD_CYC - 1);
  assign gate_d   = (gate_q & want_eff) | (settled ? joining : 4'b0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 4'b0000;
      gap_q  <= DW'(DEAD_CYC);
    end else begin
      gate_q <= gate_d;
      if (leaving != 4'b0000)        gap_q <= '0;
      else if (int'(gap_q) < DEAD_CYC) gap_q <= gap_q + 1'b1;
    end
  end

  // R10
  no_swap_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_q & ~$past(gate_q))) |-> !(|($past(gate_q) & ~gate_q)));

endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
  import chop_pkg::*;
#(
  parameter int CLK_HZ     = 40_000_000,
  parameter int BLANK_NS   = 3750,
  parameter int PERIOD_CYC = 1333,
  parameter int MIX_PCT    = 75,
  parameter int DEAD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_enable,
  input  logic       sense_trip,
  input  logic       zero_cross,
  input  logic       cur_sign,
  input  logic       cur_falling,
  input  logic [1:0] decay_sel,
  output logic       hi1_on,
  output logic       lo1_on,
  output logic       hi2_on,
  output logic       lo2_on
);
  localparam int CNT_W     = $clog2(PERIOD_CYC);
  localparam int BLANK_CYC = span_cycles(longint'(CLK_HZ), longint'(BLANK_NS));
  localparam int MIX_POS   = split_point(PERIOD_CYC, MIX_PCT);

  logic             run;
  logic             load;
  logic [CNT_W-1:0] pos;
  phase_e           phase;
  logic             sign_q;
  logic [3:0]       want;
  logic [3:0]       gate_q;

  chop_period_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (drv_enable),
    .run   (run),
    .pos   (pos),
    .load  (load)
  );

  chop_phase_seq #(
    .PERIOD_CYC (PERIOD_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .MIX_POS    (MIX_POS),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (drv_enable),
    .run     (run),
    .load    (load),
    .pos     (pos),
    .trip    (sense_trip),
    .zero    (zero_cross),
    .sign_in (cur_sign),
    .fall_in (cur_falling),
    .mode_in (decay_sel),
    .phase   (phase),
    .sign_q  (sign_q)
  );

  assign want = gate_word(phase, sign_q);

  chop_gate_deadtime #(
    .DEAD_CYC (DEAD_CYC)
  ) u_dead (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (drv_enable),
    .want   (want),
    .gate_q (gate_q)
  );

  assign {hi1_on, lo1_on, hi2_on, lo2_on} = gate_q & {4{drv_enable}};

  // R10
  leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi1_on && lo1_on) && !(hi2_on && lo2_on));

  // R1
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_enable |-> !(hi1_on || lo1_on || hi2_on || lo2_on));

endmodule

// File: tb/tb_winding_chopper.sv
module tb_winding_chopper;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       drv_enable;
  logic       sense_trip;
  logic       zero_cross;
  logic       cur_sign;
  logic       cur_falling;
  logic [1:0] decay_sel;
  logic       hi1_on, lo1_on, hi2_on, lo2_on;

  // 4 MHz -> 15 blanking clocks, 40-clock period, split at position 30.
  winding_chopper #(
    .CLK_HZ     (4_000_000),
    .BLANK_NS   (3750),
    .PERIOD_CYC (40),
    .MIX_PCT    (75),
    .DEAD_CYC   (1)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_enable  (drv_enable),
    .sense_trip  (sense_trip),
    .zero_cross  (zero_cross),
    .cur_sign    (cur_sign),
    .cur_falling (cur_falling),
    .decay_sel   (decay_sel),
    .hi1_on      (hi1_on),
    .lo1_on      (lo1_on),
    .hi2_on      (hi2_on),
    .lo2_on      (lo2_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         cyc;
    logic [3:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc    = 0;
  int   base   = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected word after edge k of the current run (edge 0 starts position 0).
  task automatic expect_at(input int k, input logic [3:0] v, input string tag);
    sb.push_back('{cyc: base + 1 + k, val: v, tag: tag});
  endtask

  task automatic expect_now(input logic [3:0] v, input string tag);
    sb.push_back('{cyc: cyc, val: v, tag: tag});
  endtask

  // Wait until the clock in which position p is current.
  task automatic to_pos(input int p);
    while (cyc < base + 1 + p) @(negedge clk);
  endtask

  task automatic start_run(input logic [1:0] mode, input logic sgn,
                           input logic fall, input logic trip_hold);
    @(negedge clk);
    drv_enable  = 1'b0;
    sense_trip  = 1'b0;
    zero_cross  = 1'b0;
    decay_sel   = mode;
    cur_sign    = sgn;
    cur_falling = fall;
    repeat (3) @(negedge clk);
    drv_enable = 1'b1;
    sense_trip = trip_hold;
    base = cyc;
  endtask

  task automatic pulse_trip(input int p);
    to_pos(p);     sense_trip = 1'b1;
    to_pos(p + 1); sense_trip = 1'b0;
  endtask

  task automatic pulse_zero(input int p);
    to_pos(p);     zero_cross = 1'b1;
    to_pos(p + 1); zero_cross = 1'b0;
  endtask

  // Monitor: pops scoreboard items as their clock comes up.
  initial begin
    exp_t it;
    logic [3:0] got;
    forever begin
      @(negedge clk);
      #1;
      got = {hi1_on, lo1_on, hi2_on, lo2_on};
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        it = sb.pop_front();
        checks++;
        if (it.cyc < cyc) begin
          fails++;
          $display("FAIL %s: item for cycle %0d missed (now %0d), expected %b",
                   it.tag, it.cyc, cyc, it.val);
        end else if (got !== it.val) begin
          fails++;
          $display("FAIL %s: cycle %0d gates %b, expected %b",
                   it.tag, cyc, got, it.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; drv_enable = 1'b0; sense_trip = 1'b0; zero_cross = 1'b0;
    cur_sign = 1'b0; cur_falling = 1'b0; decay_sel = 2'b00;
    repeat (4) @(negedge clk);
    expect_now(4'b0000, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now(4'b0000, "R1 idle");

    // Fast decay, positive, comparator stuck high: minimum on-time.
    start_run(2'b01, 1'b1, 1'b0, 1'b1);
    expect_at(0,  4'b0000, "R2 latency");
    expect_at(1,  4'b1001, "R2 drive+");
    expect_at(15, 4'b1001, "R3 blank");
    expect_at(16, 4'b1001, "R3 min on");
    expect_at(17, 4'b0000, "R10 gap");
    expect_at(18, 4'b0110, "R6 reverse");
    expect_at(39, 4'b0110, "R6 hold");
    expect_at(41, 4'b0000, "R10 gap");
    expect_at(42, 4'b1001, "R2 next period");
    to_pos(45);
    // Drop enable mid-drive, then restart.
    expect_now(4'b1001, "R2 driving");
    @(negedge clk);
    drv_enable = 1'b0;
    expect_now(4'b0000, "R1 immediate off");
    repeat (3) @(negedge clk);
    drv_enable = 1'b1;
    base = cyc;
    expect_at(1,  4'b1001, "R11 restart");
    expect_at(16, 4'b1001, "R11 full blank");
    expect_at(17, 4'b0000, "R11 gap");
    expect_at(18, 4'b0110, "R11 fast");
    to_pos(20);

    // Fast decay, negative, zero stop; trip inside blanking ignored.
    start_run(2'b01, 1'b0, 1'b0, 1'b0);
    expect_at(1,  4'b0110, "R2 drive-");
    expect_at(10, 4'b0110, "R3 blank trip ignored");
    expect_at(21, 4'b0110, "R3 drive to trip");
    expect_at(22, 4'b0000, "R10 gap");
    expect_at(23, 4'b1001, "R6 reverse-");
    expect_at(29, 4'b1001, "R6 before zero");
    expect_at(30, 4'b0000, "R6 zero stop");
    expect_at(36, 4'b0000, "R4 stays off");
    expect_at(41, 4'b0110, "R2 drive no gap");
    pulse_trip(5);
    pulse_trip(20);
    pulse_zero(28);
    pulse_trip(33);
    to_pos(42);

    // Slow decay, positive; mid-period config change.
    start_run(2'b00, 1'b1, 1'b0, 1'b0);
    expect_at(17, 4'b1001, "R3 trip at 16");
    expect_at(18, 4'b0001, "R10 common kept");
    expect_at(19, 4'b0101, "R5 slow");
    expect_at(30, 4'b0101, "R4 R5 zero ignored");
    expect_at(39, 4'b0101, "R9 old config");
    expect_at(41, 4'b0100, "R10 partial");
    expect_at(42, 4'b0110, "R9 new sign");
    expect_at(60, 4'b0110, "R3 no trip drives");
    pulse_trip(16);
    to_pos(20);
    cur_sign  = 1'b0;
    decay_sel = 2'b01;
    pulse_zero(25);
    to_pos(61);

    // Mixed, falling: fast then slow at position 30.
    start_run(2'b10, 1'b1, 1'b1, 1'b0);
    expect_at(19, 4'b0110, "R7 fast part");
    expect_at(30, 4'b0110, "R7 before split");
    expect_at(31, 4'b0100, "R7 R10 split");
    expect_at(32, 4'b0101, "R7 slow part");
    expect_at(39, 4'b0101, "R7 tail");
    pulse_trip(16);
    to_pos(40);

    // Mixed, rising: slow throughout.
    start_run(2'b10, 1'b1, 1'b0, 1'b0);
    expect_at(18, 4'b0001, "R8 gap");
    expect_at(19, 4'b0101, "R8 slow");
    expect_at(25, 4'b0101, "R8 hold");
    pulse_trip(16);
    to_pos(26);

    // Alternate mixed code, falling, zero before split.
    start_run(2'b11, 1'b1, 1'b1, 1'b0);
    expect_at(19, 4'b0110, "R7 fast");
    expect_at(22, 4'b0000, "R7 zero stop");
    expect_at(26, 4'b0000, "R7 off before split");
    expect_at(31, 4'b0101, "R7 slow after split");
    pulse_trip(16);
    pulse_zero(20);
    to_pos(33);

    @(negedge clk);
    drv_enable = 1'b0;
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule